// File: doc/BRIEF.md
# Chained DMA Command Sequencer

This block is the control engine of one DMA channel. Software loads the address of a first command descriptor, then writes a count into an 8-bit counting semaphore. While the count is nonzero and the channel is ungated, the engine fetches a three-word descriptor through a simple memory-read port. It hands the command to the data path as a transfer request and waits for a transfer-done strobe. It then reports the finished command. A descriptor can link to a following one, so long command lists run without software help. The semaphore counts down only for commands that ask for it.

A small register set controls the channel: a clock-gate bit that halts it, a self-clearing channel reset, an interrupt enable and a sticky completion flag. The control word has set and clear alias offsets. Moving data to peripherals, bus arbitration and burst shaping are handled elsewhere.

Top module: `cmdchain_dma`

## Requirements
- R1: The engine leaves idle and raises `mem_req` one cycle after it sees a nonzero semaphore with an armed command pointer and the gate clear. It stays idle while the semaphore reads 0.
- R2: When a command completes, the semaphore drops by one only if bit 1 (decrement) of that command's control word is 1.
- R3: A descriptor is three words read at pointer, pointer+4 and pointer+8, in that order: link address, control word, buffer address. If bit 0 (chain) of the control word is 1, the link becomes the next pointer. If it is 0, the chain ends.
- R4: A write to offset 3 loads the command pointer and arms it. Reading offset 3 returns the pointer.
- R5: Control bit 0 (gate) resets to 1. While it is 1 the engine does not run. When it becomes 1 the command in progress is dropped within one cycle and produces no completion.
- R6: Writing 1 to control bit 1 (reset) at offset 0 or 1 returns the engine to idle, clears the semaphore and disarms the pointer. This bit always reads 0.
- R7: Each completion sets the sticky control bit 3 (flag). `irq` equals flag AND control bit 2 (interrupt enable).
- R8: Offset 0 writes the control word. Offset 1 sets and offset 2 clears only the control bits written as 1. Offsets 0 to 2 all read the control word.
- R9: A write to offset 4 adds its low 8 bits to the semaphore, saturating at 255. A decrement in the same cycle is also applied. Offset 4 reads the count.
- R10: If the chain ends while the semaphore is still nonzero, the engine waits idle with no error until a new pointer is written, and then resumes.
- R11: During a transfer, `xfer_kind` carries control-word bits 3:2 and `xfer_buf` carries the buffer address. `cmd_done` pulses for one cycle, in the cycle after the edge that accepts `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read word offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of requested word |
| mem_rvalid | input | 1 | Read data valid, accepted while `mem_req` is high |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Command transfer in progress |
| xfer_kind | output | 2 | Command type field |
| xfer_buf | output | 32 | Command buffer address |
| xfer_done | input | 1 | Transfer finished strobe |
| cmd_done | output | 1 | One-cycle completion event |
| irq | output | 1 | Completion interrupt |

## Verification
A register write is sampled at one edge. The engine reacts to the new register value at the edge after that, so a pointer or semaphore write shows on `mem_req` two edges after the write strobe is driven. A completion shows on `cmd_done`, the semaphore and `irq` one edge after `xfer_done` is sampled. The read port is combinational. The bench's model advances at the same rising edge as the design and uses only the bench's own drives. Every output is compared in the low half of each clock period, after all of these edges have settled. Directed checks also sample one full cycle after each stimulus settles.

// File: rtl/cmdchain_pkg.sv
package cmdchain_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_XFER  = 2'd2
  } eng_state_t;

  // register word offsets
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_CTRL     = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CTRL_SET = 3'd1;
  localparam logic [REG_AW-1:0] OFS_CTRL_CLR = 3'd2;
  localparam logic [REG_AW-1:0] OFS_NEXT     = 3'd3;
  localparam logic [REG_AW-1:0] OFS_SEMA     = 3'd4;

  // control word bits
  localparam int CTL_BITS  = 4;
  localparam int BIT_GATE  = 0;
  localparam int BIT_RESET = 1;
  localparam int BIT_IEN   = 2;
  localparam int BIT_FLAG  = 3;

  // descriptor control-word fields
  localparam int CW_BITS    = 4;
  localparam int CW_CHAIN   = 0;
  localparam int CW_DEC     = 1;
  localparam int CW_KIND_LO = 2;
  localparam int KIND_W     = 2;
  localparam int DESC_WORDS = 3;
endpackage

// File: rtl/cmdchain_ctrl_regs.sv
module cmdchain_ctrl_regs
  import cmdchain_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_AW-1:0]       wr_addr,
  input  logic [CTL_BITS-1:0]     wr_bits,
  input  logic                    done_evt,
  output logic                    gate_q,
  output logic                    ien_q,
  output logic                    flag_q,
  output logic                    chan_rst,
  output logic                    irq
);
  logic is_base, is_set, is_clr, ctl_we;
  logic gate_d, ien_d, flag_d;

  assign is_base = wr_en && (wr_addr == OFS_CTRL);
  assign is_set  = wr_en && (wr_addr == OFS_CTRL_SET);
  assign is_clr  = wr_en && (wr_addr == OFS_CTRL_CLR);
  assign ctl_we  = is_base || is_set || is_clr || done_evt;

  assign chan_rst = (is_base || is_set) && wr_bits[BIT_RESET];
  assign irq      = flag_q & ien_q;

  always_comb begin
    gate_d = gate_q;
    ien_d  = ien_q;
    flag_d = flag_q;
    if (is_base) begin
      gate_d = wr_bits[BIT_GATE];
      ien_d  = wr_bits[BIT_IEN];
      flag_d = wr_bits[BIT_FLAG];
    end else if (is_set) begin
      gate_d = gate_q | wr_bits[BIT_GATE];
      ien_d  = ien_q  | wr_bits[BIT_IEN];
      flag_d = flag_q | wr_bits[BIT_FLAG];
    end else if (is_clr) begin
      gate_d = gate_q & ~wr_bits[BIT_GATE];
      ien_d  = ien_q  & ~wr_bits[BIT_IEN];
      flag_d = flag_q & ~wr_bits[BIT_FLAG];
    end
    if (done_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b1;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (ctl_we) begin
      gate_q <= gate_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
    end
  end

  // completion always leaves the flag set
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> flag_q) else $error("p_flag_sticky_r7");
  // a set alias write never lowers the gate
  p_set_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_set && gate_q) |=> gate_q) else $error("p_set_only_r8");
endmodule

// File: rtl/cmdchain_sema.sv
module cmdchain_sema #(
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic [SEMA_W-1:0] add_val,
  input  logic              dec,
  input  logic              clr,
  output logic [SEMA_W-1:0] count,
  output logic              nonzero
);
  localparam logic [SEMA_W:0]   CAP = {1'b0, {SEMA_W{1'b1}}};
  localparam logic [SEMA_W:0]   ONE = {{SEMA_W{1'b0}}, 1'b1};

  logic [SEMA_W:0]   tot;
  logic [SEMA_W-1:0] cnt_d;
  logic              cnt_we;

  assign cnt_we  = add_en | dec | clr;
  assign nonzero = (count != '0);

  always_comb begin
    tot = {1'b0, count} + (add_en ? {1'b0, add_val} : '0);
    if (dec && (tot != '0)) tot = tot - ONE;
    if (tot > CAP) cnt_d = CAP[SEMA_W-1:0];
    else           cnt_d = tot[SEMA_W-1:0];
    if (clr) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_we) count <= cnt_d;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !add_en && !clr) |=> (count == $past(count))) else $error("p_hold_r2");
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count) && !dec && !clr) |=> (&count)) else $error("p_saturate_r9");
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)) else $error("p_clear_r6");
endmodule

// File: rtl/cmdchain_engine.sv
module cmdchain_engine
  import cmdchain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_q,
  input  logic              chan_rst,
  input  logic              sema_nz,
  input  logic              nxt_wr,
  input  logic [ADDR_W-1:0] nxt_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              xfer_req,
  output logic [KIND_W-1:0] xfer_kind,
  output logic [ADDR_W-1:0] xfer_buf,
  input  logic              xfer_done,
  output logic              done_evt,
  output logic              dec_evt,
  output logic              cmd_done,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LINK = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CW   = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  eng_state_t         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [ADDR_W-1:0]  ptr_q, ptr_d, link_q, link_d, buf_q, buf_d;
  logic [CW_BITS-1:0] cw_q, cw_d;
  logic               armed_q, armed_d;
  logic               abort;

  assign abort    = chan_rst | gate_q;
  assign done_evt = (state_q == ENG_XFER) & xfer_done & ~abort;
  assign dec_evt  = done_evt & cw_q[CW_DEC];

  assign mem_req   = (state_q == ENG_FETCH);
  assign mem_addr  = ptr_q + ADDR_W'({idx_q, 2'b00});
  assign xfer_req  = (state_q == ENG_XFER);
  assign xfer_kind = cw_q[CW_KIND_LO +: KIND_W];
  assign xfer_buf  = buf_q;
  assign ptr_o     = ptr_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    armed_d = armed_q;
    link_d  = link_q;
    cw_d    = cw_q;
    buf_d   = buf_q;
    if (abort) begin
      state_d = ENG_IDLE;
      idx_d   = '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (sema_nz && armed_q) begin
            state_d = ENG_FETCH;
            idx_d   = '0;
          end
        end
        ENG_FETCH: begin
          if (mem_rvalid) begin
            if (idx_q == IDX_LINK)    link_d = mem_rdata;
            else if (idx_q == IDX_CW) cw_d   = mem_rdata[CW_BITS-1:0];
            else                      buf_d  = mem_rdata;
            if (idx_q == IDX_LAST) begin
              state_d = ENG_XFER;
              idx_d   = '0;
            end else begin
              idx_d = idx_q + IDX_ONE;
            end
          end
        end
        ENG_XFER: begin
          if (xfer_done) begin
            state_d = ENG_IDLE;
            if (cw_q[CW_CHAIN]) ptr_d   = link_q;
            else                armed_d = 1'b0;
          end
        end
        default: state_d = ENG_IDLE;
      endcase
    end
    if (nxt_wr) begin
      ptr_d   = nxt_data;
      armed_d = 1'b1;
    end
    if (chan_rst) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      idx_q    <= '0;
      ptr_q    <= '0;
      armed_q  <= 1'b0;
      link_q   <= '0;
      cw_q     <= '0;
      buf_q    <= '0;
      cmd_done <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      ptr_q    <= ptr_d;
      armed_q  <= armed_d;
      link_q   <= link_d;
      cw_q     <= cw_d;
      buf_q    <= buf_d;
      cmd_done <= done_evt;
    end
  end

  p_stop_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ENG_IDLE) && !sema_nz) |=> (state_q == ENG_IDLE)) else $error("p_stop_at_zero_r1");
  p_fetch_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ENG_FETCH) && mem_rvalid && (idx_q == IDX_LAST) && !abort) |=> (state_q == ENG_XFER))
    else $error("p_fetch_order_r3");
  p_chain_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !cw_q[CW_CHAIN] && !nxt_wr) |=> !armed_q) else $error("p_chain_end_r3");
  p_gate_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |=> (state_q == ENG_IDLE)) else $error("p_gate_halts_r5");
  p_reset_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> ((state_q == ENG_IDLE) && !armed_q)) else $error("p_reset_idle_r6");
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (cmd_done && !xfer_req)) else $error("p_done_pulse_r11");
endmodule

// File: rtl/cmdchain_dma.sv
module cmdchain_dma
  import cmdchain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [2:0]        reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              xfer_req,
  output logic [1:0]        xfer_kind,
  output logic [ADDR_W-1:0] xfer_buf,
  input  logic              xfer_done,
  output logic              cmd_done,
  output logic              irq
);
  logic              gate_q, ien_q, flag_q, chan_rst;
  logic              done_evt, dec_evt, sema_nz, nxt_wr, sema_wr;
  logic [SEMA_W-1:0] sema_cnt;
  logic [ADDR_W-1:0] ptr;

  assign nxt_wr  = reg_wr_en && (reg_wr_addr == OFS_NEXT);
  assign sema_wr = reg_wr_en && (reg_wr_addr == OFS_SEMA);

  cmdchain_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_wr_addr),
    .wr_bits  (reg_wr_data[CTL_BITS-1:0]),
    .done_evt (done_evt),
    .gate_q   (gate_q),
    .ien_q    (ien_q),
    .flag_q   (flag_q),
    .chan_rst (chan_rst),
    .irq      (irq)
  );

  cmdchain_sema #(.SEMA_W(SEMA_W)) u_sema (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (sema_wr),
    .add_val (reg_wr_data[SEMA_W-1:0]),
    .dec     (dec_evt),
    .clr     (chan_rst),
    .count   (sema_cnt),
    .nonzero (sema_nz)
  );

  cmdchain_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_q     (gate_q),
    .chan_rst   (chan_rst),
    .sema_nz    (sema_nz),
    .nxt_wr     (nxt_wr),
    .nxt_data   (ADDR_W'(reg_wr_data)),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (ADDR_W'(mem_rdata)),
    .xfer_req   (xfer_req),
    .xfer_kind  (xfer_kind),
    .xfer_buf   (xfer_buf),
    .xfer_done  (xfer_done),
    .done_evt   (done_evt),
    .dec_evt    (dec_evt),
    .cmd_done   (cmd_done),
    .ptr_o      (ptr)
  );

  always_comb begin
    reg_rd_data = '0;
    case (reg_rd_addr)
      OFS_CTRL, OFS_CTRL_SET, OFS_CTRL_CLR: begin
        reg_rd_data[BIT_GATE] = gate_q;
        reg_rd_data[BIT_IEN]  = ien_q;
        reg_rd_data[BIT_FLAG] = flag_q;
      end
      OFS_NEXT: reg_rd_data = DATA_W'(ptr);
      OFS_SEMA: reg_rd_data[SEMA_W-1:0] = sema_cnt;
      default:  reg_rd_data = '0;
    endcase
  end

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && ien_q) |-> irq) else $error("p_irq_follows_r7");
endmodule

// File: tb/cmdchain_dma_bench.sv
`timescale 1ns/1ps
module cmdchain_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        xfer_req;
  logic [1:0]  xfer_kind;
  logic [31:0] xfer_buf;
  logic        xfer_done = 1'b0;
  logic        cmd_done;
  logic        irq;

  always #2.5 clk = ~clk;

  cmdchain_dma u_cmdchain_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_req(xfer_req), .xfer_kind(xfer_kind), .xfer_buf(xfer_buf), .xfer_done(xfer_done),
    .cmd_done(cmd_done), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;
  bit finished = 1'b0;
  logic [31:0] mem [0:63];
  bit   hold_xfer = 1'b0;
  int   xcnt = 0;
  bit   rd_hold = 1'b0;
  logic [2:0] rd_pin = '0;
  int   rot = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory and transfer responders
  always @(negedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= mem[mem_addr[7:2]];
    if (xfer_req && !hold_xfer) begin
      if (xcnt == 2) begin xfer_done <= 1'b1; xcnt <= 0; end
      else begin xfer_done <= 1'b0; xcnt <= xcnt + 1; end
    end else begin
      xfer_done <= 1'b0;
      xcnt <= 0;
    end
    rot <= (rot + 1) % 5;
    reg_rd_addr <= rd_hold ? rd_pin : 3'(rot);
  end

  // behavioural reference model
  int m_phase, m_idx, m_sema, s;
  logic [31:0] m_ptr, m_link, m_cw, m_buf;
  bit m_armed, m_gate, m_ien, m_flag, m_done, rp, ab, dn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_idx = 0; m_sema = 0; m_ptr = 0; m_link = 0; m_cw = 0; m_buf = 0;
      m_armed = 0; m_gate = 1; m_ien = 0; m_flag = 0; m_done = 0;
    end else begin
      rp = reg_wr_en && (reg_wr_addr == 0 || reg_wr_addr == 1) && reg_wr_data[1];
      ab = rp || m_gate;
      dn = !ab && (m_phase == 2) && xfer_done;
      s = m_sema + ((reg_wr_en && reg_wr_addr == 4) ? int'(reg_wr_data[7:0]) : 0);
      if (dn && m_cw[1] && s > 0) s--;
      if (s > 255) s = 255;
      if (rp) s = 0;
      if (ab) begin m_phase = 0; m_idx = 0; end
      else if (m_phase == 0) begin
        if (m_sema != 0 && m_armed) begin m_phase = 1; m_idx = 0; end
      end else if (m_phase == 1) begin
        if (mem_rvalid) begin
          if (m_idx == 0) m_link = mem_rdata;
          else if (m_idx == 1) m_cw = mem_rdata;
          else m_buf = mem_rdata;
          if (m_idx == 2) begin m_phase = 2; m_idx = 0; end
          else m_idx++;
        end
      end else if (m_phase == 2 && xfer_done) begin
        m_phase = 0;
        if (m_cw[0]) m_ptr = m_link; else m_armed = 0;
      end
      if (reg_wr_en && reg_wr_addr == 3) begin m_ptr = reg_wr_data; m_armed = 1; end
      if (rp) m_armed = 0;
      if (reg_wr_en) begin
        case (reg_wr_addr)
          3'd0: begin m_gate = reg_wr_data[0]; m_ien = reg_wr_data[2]; m_flag = reg_wr_data[3]; end
          3'd1: begin m_gate |= reg_wr_data[0]; m_ien |= reg_wr_data[2]; m_flag |= reg_wr_data[3]; end
          3'd2: begin m_gate &= ~reg_wr_data[0]; m_ien &= ~reg_wr_data[2]; m_flag &= ~reg_wr_data[3]; end
          default: ;
        endcase
      end
      if (dn) m_flag = 1;
      m_done = dn;
      m_sema = s;
    end
  end

  // every-cycle comparison in the low half of the period
  logic [31:0] exp_rd;
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk(mem_req == (m_phase == 1), "R3 mem_req", 32'(mem_req), 32'(m_phase == 1));
      if (mem_req) chk(mem_addr == m_ptr + 32'(4 * m_idx), "R3 mem_addr", mem_addr, m_ptr + 32'(4 * m_idx));
      chk(xfer_req == (m_phase == 2), "R11 xfer_req", 32'(xfer_req), 32'(m_phase == 2));
      if (xfer_req) begin
        chk(xfer_kind == m_cw[3:2], "R11 xfer_kind", 32'(xfer_kind), 32'(m_cw[3:2]));
        chk(xfer_buf == m_buf, "R11 xfer_buf", xfer_buf, m_buf);
      end
      chk(cmd_done == m_done, "R11 cmd_done", 32'(cmd_done), 32'(m_done));
      chk(irq == (m_flag && m_ien), "R7 irq", 32'(irq), 32'(m_flag && m_ien));
      case (reg_rd_addr)
        3'd0, 3'd1, 3'd2: exp_rd = {28'd0, m_flag, m_ien, 1'b0, m_gate};
        3'd3: exp_rd = m_ptr;
        3'd4: exp_rd = 32'(m_sema);
        default: exp_rd = 32'd0;
      endcase
      chk(reg_rd_data == exp_rd, "R8 R9 reg_rd_data", reg_rd_data, exp_rd);
      if (cmd_done) done_cnt++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_pin = a; rd_hold = 1'b1;
    @(negedge clk); #1;
    chk(reg_rd_data == exp, tag, reg_rd_data, exp);
    rd_hold = 1'b0;
  endtask

  task automatic wait_xfer();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (xfer_req) break;
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  int base;
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[0]  = 32'h0C; mem[1]  = 32'h7; mem[2]  = 32'h1000;
    mem[3]  = 32'h18; mem[4]  = 32'hB; mem[5]  = 32'h2000;
    mem[6]  = 32'h00; mem[7]  = 32'hE; mem[8]  = 32'h3000;
    mem[12] = 32'h3C; mem[13] = 32'h1; mem[14] = 32'h4000;
    mem[15] = 32'h00; mem[16] = 32'h6; mem[17] = 32'h5000;
    mem[24] = 32'h00; mem[25] = 32'hA; mem[26] = 32'h6000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state: gated, empty semaphore
    rd_check(3'd0, 32'h1, "R5 reset ctrl");
    rd_check(3'd4, 32'h0, "R1 reset sema");
    chk(!irq, "R7 reset irq", 32'(irq), 0);

    // gated channel does not run
    wr(3'd3, 32'h0);
    wr(3'd4, 32'd3);
    repeat (10) @(negedge clk);
    #1 chk(!mem_req && !xfer_req, "R5 gated idle", 32'(mem_req), 0);
    rd_check(3'd4, 32'd3, "R5 sema kept");
    rd_check(3'd3, 32'h0, "R4 pointer read");

    // ungate via clear alias, enable irq via set alias, run three linked commands
    base = done_cnt;
    wr(3'd2, 32'h1);
    wr(3'd1, 32'h4);
    repeat (80) @(negedge clk);
    rd_check(3'd4, 32'd0, "R2 all decremented");
    chk(done_cnt - base == 3, "R3 chain length", 32'(done_cnt - base), 3);
    #1 chk(irq, "R7 irq raised", 32'(irq), 1);
    rd_check(3'd0, 32'hC, "R8 ctrl after aliases");
    wr(3'd2, 32'h8);
    #1 chk(!irq, "R7 irq cleared", 32'(irq), 0);
    rd_check(3'd0, 32'h4, "R8 clear only flag");

    // chain with one non-decrementing command
    base = done_cnt;
    wr(3'd3, 32'h30);
    wr(3'd4, 32'd1);
    repeat (60) @(negedge clk);
    rd_check(3'd4, 32'd0, "R2 single decrement");
    chk(done_cnt - base == 2, "R2 both commands ran", 32'(done_cnt - base), 2);

    // chain ends with count left over, then resumes on a new pointer
    base = done_cnt;
    wr(3'd4, 32'd2);
    wr(3'd3, 32'h60);
    @(negedge clk); #1;
    chk(mem_req, "R1 start latency", 32'(mem_req), 1);
    repeat (40) @(negedge clk);
    rd_check(3'd4, 32'd1, "R10 count left");
    #1 chk(!mem_req && !xfer_req, "R10 idle waiting", 32'(mem_req | xfer_req), 0);
    rd_check(3'd3, 32'h60, "R4 pointer loaded");
    wr(3'd3, 32'h60);
    repeat (40) @(negedge clk);
    rd_check(3'd4, 32'd0, "R10 resumed");
    chk(done_cnt - base == 2, "R10 completions", 32'(done_cnt - base), 2);

    // saturation and channel reset
    wr(3'd4, 32'd200);
    wr(3'd4, 32'd100);
    rd_check(3'd4, 32'd255, "R9 saturate");
    wr(3'd1, 32'h2);
    rd_check(3'd4, 32'd0, "R6 sema cleared");
    rd_check(3'd0, 32'hC, "R6 reset bit reads 0");

    // extend a running chain
    base = done_cnt;
    wr(3'd3, 32'h0);
    wr(3'd4, 32'd1);
    wait_xfer();
    wr(3'd4, 32'd2);
    repeat (80) @(negedge clk);
    rd_check(3'd4, 32'd0, "R9 add while running");
    chk(done_cnt - base == 3, "R9 extended chain", 32'(done_cnt - base), 3);

    // gate aborts a command in flight
    base = done_cnt;
    hold_xfer = 1'b1;
    wr(3'd3, 32'h60);
    wr(3'd4, 32'd1);
    wait_xfer();
    wr(3'd1, 32'h1);
    repeat (3) @(negedge clk);
    #1 chk(!xfer_req, "R5 abort", 32'(xfer_req), 0);
    rd_check(3'd4, 32'd1, "R5 no decrement on abort");
    chk(done_cnt == base, "R5 no completion", 32'(done_cnt - base), 0);

    // reset during a restarted run
    wr(3'd2, 32'h1);
    wait_xfer();
    wr(3'd1, 32'h2);
    repeat (2) @(negedge clk);
    #1 chk(!xfer_req && !mem_req, "R6 idle after reset", 32'(xfer_req | mem_req), 0);
    rd_check(3'd4, 32'd0, "R6 sema zero");
    hold_xfer = 1'b0;
    repeat (20) @(negedge clk);
    #1 chk(!mem_req && !xfer_req, "R6 disarmed", 32'(mem_req | xfer_req), 0);
    chk(done_cnt == base, "R6 no completion", 32'(done_cnt - base), 0);

    summary();
  end
endmodule